// File: doc/BRIEF.md
# Receive Line Alarm Monitor

This block sits behind a line receiver's clock recovery and watches the recovered bit stream, one bit per cycle in which `bit_en` is high. It derives four alarm conditions, and the criteria for them depend on whether the line runs the 2.048 Mbit/s (E1) or the 1.544 Mbit/s (T1) standard: an unframed all-ones (AIS) indication judged over fixed, non-overlapping bit windows, carrier loss after a long run of zeros, a short zero-run flag and a 16-zero-run flag.

The live conditions are visible at all times. Each one also feeds a latched bit that is set when the condition rises. Software reads the latched bits with a write-then-read sequence. It first loads a selection mask, and a read strobe then returns the selected latched bits and clears exactly those bits. Any latched bit whose interrupt mask bit is 0 drives the interrupt output.

Status bit order, used by every status vector: [0] AIS, [1] carrier loss, [2] zero-run detect, [3] sixteen-zero run.

Top module: `rx_alarm_monitor`

## Requirements
- R1: With `t1_mode`=0, at the last bit of each E1_WIN-bit window (default 512), AIS (bit 0) becomes 1 if the window held fewer than two zeros, otherwise 0; it keeps its value between window ends.
- R2: With `t1_mode`=1, at the last bit of each T1_WIN-bit window (default 4632), AIS becomes 1 if the window held five or fewer zeros, otherwise 0.
- R3: Carrier loss (bit 1) sets on the bit that completes CL_SHORT consecutive zeros (default 255) when `cl_long_sel`=0, or CL_LONG consecutive zeros (default 2048) when `cl_long_sel`=1.
- R4: While carrier loss is set, the bits are grouped into REC_WIN-bit windows (default 32) that start with the bit after it set; carrier loss clears at the end of a window holding at least REC_WIN/8 ones.
- R5: Zero-run detect (bit 2) is 1 while the current run of zeros is at least 4 long (`t1_mode`=0) or at least 8 long (`t1_mode`=1); a one clears it.
- R6: The sixteen-zero flag (bit 3) is 1 while the current zero run is at least 16 long; a one clears it.
- R7: A latched bit sets in the cycle after its live bit rises and stays set until cleared by a read that selects it.
- R8: `sel_wr` loads `sel_mask` as the read selection; a `rd_en` cycle makes `rd_data` equal to latched AND selection in the next cycle and clears the selected latched bits, while unselected bits stay set.
- R9: `irq` is 1 exactly when some latched bit is set and the matching `int_mask` bit is 0.
- R10: Cycles with `bit_en`=0 leave every detector unchanged, whatever `rx_data` holds.
- R11: After reset, `live_status`, `rd_data` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | Marks a cycle carrying one received bit |
| rx_data | input | 1 | Received bit value |
| t1_mode | input | 1 | 1 selects T1 criteria, 0 selects E1 criteria |
| cl_long_sel | input | 1 | 1 selects the long carrier-loss run length |
| sel_wr | input | 1 | Loads the read selection mask |
| sel_mask | input | 4 | Read selection, one bit per status bit |
| rd_en | input | 1 | Read strobe: return and clear selected latched bits |
| int_mask | input | 4 | 1 keeps the matching latched bit off the interrupt |
| live_status | output | 4 | Current alarm conditions |
| rd_data | output | 4 | Latched bits returned by the last read |
| irq | output | 1 | Interrupt request |

## Verification
Every detector registers once on a bit cycle, so a live bit reflects a received bit right after the clock edge that takes it in; the bench drives each bit for one cycle and samples on the following falling edge. A latched bit follows its live bit one edge later, so latch and interrupt checks wait one further cycle, and `rd_data` is sampled in the cycle after the read strobe. AIS is compared only after the last bit of a window, with windows kept aligned by resetting before each mode sweep.

// File: rtl/rxam_pkg.sv
package rxam_pkg;
    localparam int ST_AIS = 0;
    localparam int ST_CL  = 1;
    localparam int ST_ZD  = 2;
    localparam int ST_Z16 = 3;
    localparam int ST_W   = 4;
    typedef logic [ST_W-1:0] status_t;
endpackage

// File: rtl/rxam_zero_run.sv
module rxam_zero_run #(
    parameter int CL_SHORT = 255,
    parameter int CL_LONG  = 2048,
    parameter int REC_WIN  = 32,
    parameter int Z16_LEN  = 16,
    parameter int ZD_E1    = 4,
    parameter int ZD_T1    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rx_data,
    input  logic t1_mode,
    input  logic cl_long_sel,
    output logic cl_live,
    output logic zd_live,
    output logic z16_live
);
    localparam int RUN_MAX  = (CL_LONG > Z16_LEN) ? CL_LONG : Z16_LEN;
    localparam int RUN_W    = $clog2(RUN_MAX + 1);
    localparam int REC_W    = $clog2(REC_WIN);
    localparam int ONES_W   = $clog2(REC_WIN + 1);
    localparam int ONES_MIN = REC_WIN / 8;

    typedef struct packed {
        logic [RUN_W-1:0]  run;
        logic              cl;
        logic [REC_W-1:0]  rcnt;
        logic [ONES_W-1:0] ones;
    } zr_state_t;

    zr_state_t s_d, s_q;
    int        cl_thr;
    logic      cl_set;

    always_comb begin
        s_d    = s_q;
        cl_thr = cl_long_sel ? CL_LONG : CL_SHORT;
        cl_set = 1'b0;
        if (!s_q.cl) begin
            s_d.rcnt = '0;
            s_d.ones = '0;
        end
        if (bit_en) begin
            if (rx_data) begin
                s_d.run = '0;
            end else if (int'(s_q.run) != RUN_MAX) begin
                s_d.run = s_q.run + 1'b1;
            end
            cl_set = !rx_data && (int'(s_q.run) + 1 >= cl_thr);
            if (s_q.cl) begin
                if (s_q.rcnt == REC_W'(REC_WIN - 1)) begin
                    s_d.rcnt = '0;
                    s_d.ones = '0;
                    if (int'(s_q.ones) + int'(rx_data) >= ONES_MIN) begin
                        s_d.cl = 1'b0;
                    end
                end else begin
                    s_d.rcnt = s_q.rcnt + 1'b1;
                    s_d.ones = s_q.ones + ONES_W'(rx_data);
                end
            end
            if (cl_set) begin
                s_d.cl = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cl_live  = s_q.cl;
    assign zd_live  = int'(s_q.run) >= (t1_mode ? ZD_T1 : ZD_E1);
    assign z16_live = int'(s_q.run) >= Z16_LEN;

    assert_one_ends_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && rx_data) |=> (!z16_live && !zd_live));

    assert_cl_needs_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.cl) |-> (int'(s_q.run) >= ($past(cl_long_sel) ? CL_LONG : CL_SHORT)));

    assert_idle_keeps_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(s_q.run) && $stable(s_q.cl)));
endmodule

// File: rtl/rxam_ais_window.sv
module rxam_ais_window #(
    parameter int E1_WIN        = 512,
    parameter int T1_WIN        = 4632,
    parameter int E1_ZERO_BELOW = 2,
    parameter int T1_ZERO_MAX   = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rx_data,
    input  logic t1_mode,
    output logic ais_live
);
    localparam int WIN_MAX = (E1_WIN > T1_WIN) ? E1_WIN : T1_WIN;
    localparam int CNT_W   = $clog2(WIN_MAX);
    localparam int ZSAT    = T1_ZERO_MAX + 2;
    localparam int Z_W     = $clog2(ZSAT + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [Z_W-1:0]   zeros;
        logic             ais;
    } aw_state_t;

    aw_state_t s_d, s_q;
    int        wlen;
    int        ztot;

    always_comb begin
        s_d  = s_q;
        wlen = t1_mode ? T1_WIN : E1_WIN;
        ztot = int'(s_q.zeros) + (rx_data ? 0 : 1);
        if (bit_en) begin
            if (int'(s_q.cnt) >= wlen - 1) begin
                s_d.cnt   = '0;
                s_d.zeros = '0;
                s_d.ais   = t1_mode ? (ztot <= T1_ZERO_MAX) : (ztot < E1_ZERO_BELOW);
            end else begin
                s_d.cnt   = s_q.cnt + 1'b1;
                s_d.zeros = (ztot > ZSAT) ? Z_W'(ZSAT) : Z_W'(ztot);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ais_live = s_q.ais;

    assert_idle_keeps_ais_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(s_q.ais) && $stable(s_q.cnt)));

    assert_ais_moves_at_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && s_q.cnt == '0 && wlen > 1) |=> $stable(s_q.ais));
endmodule

// File: rtl/rxam_status_reg.sv
module rxam_status_reg
    import rxam_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  status_t live,
    input  logic    sel_wr,
    input  status_t sel_mask,
    input  logic    rd_en,
    input  status_t int_mask,
    output status_t rd_data,
    output logic    irq
);
    typedef struct packed {
        status_t prev;
        status_t lat;
        status_t mask;
        status_t rd;
    } sr_state_t;

    sr_state_t s_d, s_q;
    status_t   rise;
    status_t   clr;

    always_comb begin
        s_d      = s_q;
        rise     = live & ~s_q.prev;
        clr      = rd_en ? s_q.mask : '0;
        s_d.prev = live;
        s_d.lat  = (s_q.lat & ~clr) | rise;
        if (rd_en) begin
            s_d.rd = s_q.lat & s_q.mask;
        end
        if (sel_wr) begin
            s_d.mask = sel_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data = s_q.rd;
    assign irq     = |(s_q.lat & ~int_mask);

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ((rise & s_q.mask) == '0)) |=> ((s_q.lat & $past(s_q.mask)) == '0));

    assert_latch_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> ((s_q.lat & $past(s_q.lat)) == $past(s_q.lat)));
endmodule

// File: rtl/rx_alarm_monitor.sv
module rx_alarm_monitor
    import rxam_pkg::*;
#(
    parameter int E1_WIN   = 512,
    parameter int T1_WIN   = 4632,
    parameter int CL_SHORT = 255,
    parameter int CL_LONG  = 2048,
    parameter int REC_WIN  = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       rx_data,
    input  logic       t1_mode,
    input  logic       cl_long_sel,
    input  logic       sel_wr,
    input  logic [3:0] sel_mask,
    input  logic       rd_en,
    input  logic [3:0] int_mask,
    output logic [3:0] live_status,
    output logic [3:0] rd_data,
    output logic       irq
);
    logic    ais_w, cl_w, zd_w, z16_w;
    status_t live_w;

    rxam_ais_window #(
        .E1_WIN (E1_WIN),
        .T1_WIN (T1_WIN)
    ) u_ais (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .rx_data  (rx_data),
        .t1_mode  (t1_mode),
        .ais_live (ais_w)
    );

    rxam_zero_run #(
        .CL_SHORT (CL_SHORT),
        .CL_LONG  (CL_LONG),
        .REC_WIN  (REC_WIN)
    ) u_zrun (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (bit_en),
        .rx_data     (rx_data),
        .t1_mode     (t1_mode),
        .cl_long_sel (cl_long_sel),
        .cl_live     (cl_w),
        .zd_live     (zd_w),
        .z16_live    (z16_w)
    );

    always_comb begin
        live_w         = '0;
        live_w[ST_AIS] = ais_w;
        live_w[ST_CL]  = cl_w;
        live_w[ST_ZD]  = zd_w;
        live_w[ST_Z16] = z16_w;
    end

    rxam_status_reg u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .live     (live_w),
        .sel_wr   (sel_wr),
        .sel_mask (sel_mask),
        .rd_en    (rd_en),
        .int_mask (int_mask),
        .rd_data  (rd_data),
        .irq      (irq)
    );

    assign live_status = live_w;
endmodule

// File: tb/sim_rx_alarm_monitor.sv
module sim_rx_alarm_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int E1W = 16, T1W = 24, CLS = 10, CLL = 20, RECW = 16;

    logic clk = 0, rst_n = 0, bit_en = 0, rx_data = 0, t1_mode = 0, cl_long_sel = 0;
    logic sel_wr = 0, rd_en = 0;
    logic [3:0] sel_mask = 0, int_mask = 0;
    logic [3:0] live_status, rd_data;
    logic irq;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_alarm_monitor #(.E1_WIN(E1W), .T1_WIN(T1W), .CL_SHORT(CLS), .CL_LONG(CLL), .REC_WIN(RECW)) u0 (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_data(rx_data), .t1_mode(t1_mode),
        .cl_long_sel(cl_long_sel), .sel_wr(sel_wr), .sel_mask(sel_mask), .rd_en(rd_en),
        .int_mask(int_mask), .live_status(live_status), .rd_data(rd_data), .irq(irq));

    task automatic check(string req, logic [3:0] act, logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0; bit_en = 0; rd_en = 0; sel_wr = 0;
        @(negedge clk); rst_n = 1;
    endtask

    task automatic send_bit(logic b);
        @(negedge clk); bit_en = 1; rx_data = b;
        @(negedge clk); bit_en = 0;
    endtask

    task automatic load_sel(logic [3:0] m);
        @(negedge clk); sel_wr = 1; sel_mask = m;
        @(negedge clk); sel_wr = 0;
    endtask

    task automatic do_read();
        @(negedge clk); rd_en = 1;
        @(negedge clk); rd_en = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R11 reset state
        do_reset();
        check("R11 live", live_status, 4'b0000);
        check("R11 rd_data", rd_data, 4'b0000);
        check("R11 irq", {3'b0, irq}, 4'b0000);

        // R1 E1 AIS: zeros spread on even positions
        t1_mode = 0; cl_long_sel = 1;
        do_reset();
        for (int nz = 0; nz <= 4; nz++) begin
            for (int i = 0; i < E1W; i++) send_bit(!((i % 2 == 0) && (i / 2 < nz)));
            check("R1 ais", {3'b0, live_status[0]}, {3'b0, nz < 2});
        end

        // R2 T1 AIS
        t1_mode = 1;
        do_reset();
        for (int nz = 3; nz <= 8; nz++) begin
            for (int i = 0; i < T1W; i++) send_bit(!((i % 2 == 0) && (i / 2 < nz)));
            check("R2 ais", {3'b0, live_status[0]}, {3'b0, nz <= 5});
        end

        // R5 / R6 zero-run flags, long carrier threshold keeps carrier loss off
        for (int m = 0; m < 2; m++) begin
            t1_mode = logic'(m); cl_long_sel = 1;
            do_reset();
            for (int len = 1; len <= 18; len++) begin
                send_bit(1);
                for (int k = 1; k <= len; k++) begin
                    send_bit(0);
                    check("R5 zd", {3'b0, live_status[2]}, {3'b0, k >= (m ? 8 : 4)});
                    check("R6 z16", {3'b0, live_status[3]}, {3'b0, k >= 16});
                end
            end
            send_bit(1);
            check("R6 cleared by one", {2'b0, live_status[3:2]}, 4'b0000);
        end

        // R10 idle cycles with zero data change nothing
        t1_mode = 0; do_reset();
        send_bit(1);
        @(negedge clk); rx_data = 0;
        repeat (40) @(negedge clk);
        check("R10 idle", live_status, 4'b0000);

        // R3 / R4 carrier loss, short threshold then recovery
        cl_long_sel = 0; do_reset();
        send_bit(1);
        for (int k = 1; k < CLS; k++) send_bit(0);
        check("R3 below short", {3'b0, live_status[1]}, 4'b0000);
        send_bit(0);
        check("R3 at short", {3'b0, live_status[1]}, 4'b0001);
        for (int i = 0; i < RECW; i++) send_bit(i == 7);
        check("R4 one one kept", {3'b0, live_status[1]}, 4'b0001);
        for (int i = 0; i < RECW; i++) send_bit(i == 5 || i == 13);
        check("R4 cleared", {3'b0, live_status[1]}, 4'b0000);
        cl_long_sel = 1;
        send_bit(1);
        for (int k = 1; k < CLL; k++) send_bit(0);
        check("R3 below long", {3'b0, live_status[1]}, 4'b0000);
        send_bit(0);
        check("R3 at long", {3'b0, live_status[1]}, 4'b0001);

        // R7 / R8 / R9 latching, readout, interrupt
        t1_mode = 0; cl_long_sel = 1; int_mask = 4'b0000; do_reset();
        for (int k = 0; k < 4; k++) send_bit(0);
        @(negedge clk);
        check("R7 latched irq", {3'b0, irq}, 4'b0001);
        int_mask = 4'b0100; #1;
        check("R9 masked", {3'b0, irq}, 4'b0000);
        int_mask = 4'b0000;
        load_sel(4'b0001); do_read();
        check("R8 unselected read", rd_data, 4'b0000);
        check("R8 unselected kept", {3'b0, irq}, 4'b0001);
        load_sel(4'b0100); do_read();
        check("R8 selected read", rd_data, 4'b0100);
        check("R8 cleared", {3'b0, irq}, 4'b0000);
        do_read();
        check("R7 no new rise", rd_data, 4'b0000);
        send_bit(1); send_bit(0); send_bit(0); send_bit(0); send_bit(0);
        @(negedge clk);
        load_sel(4'b1111); do_read();
        check("R7 relatch", rd_data, 4'b0100);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule